// File: doc/BRIEF.md
# Measurement Configuration Register Bank

This block holds the configuration and status state of an ultrasonic time-of-flight measurement engine. Ten 8-bit registers sit behind a plain synchronous bus made of an address, write data, a write strobe, a read strobe and registered read data. The measurement logic gets the decoded fields directly: burst divider and pulse count, averaging and receive-event counts, mode, echo threshold, the 10-bit timing length and the listening-window selection.

One register gathers receive-side error events into sticky flags. While any flag is set, an active-low error pin is driven low. Writing ones to that register does not set anything. One bit, when written as 1, clears every flag and releases the pin. Another bit, when written as 1, clears the missing-signal flag and also sends a single-cycle abort pulse to the measurement sequencer. That pulse stops the run, and resets the averaging count and the automatic channel choice.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, addresses 0x0 to 0x9 read 0x45, 0x40, 0x00, 0x03, 0x1F, 0x00, 0x00, 0x00, 0x19 and 0x00.
- R2: A write to 0x0–0x6, 0x8 or 0x9 stores all 8 bits. A read strobe presents the addressed value on the read data in the cycle after the strobe, and the read data holds between reads.
- R3: Writes to addresses 0xA–0xF change no register, and reads of those addresses return 0x00.
- R4: The timing length output equals {register 0x5 bits [1:0], register 0x6 bits [7:0]}. The echo threshold output equals register 0x3 bits [2:0].
- R5: Register 0x7 reads {5'b0, weak, none, high}, with the weak-signal flag in bit 2, the no-signal flag in bit 1 and the too-high flag in bit 0. A write to it never sets a flag, and writing 1 to bit 2 has no effect.
- R6: A weak-signal or no-signal event pulse sets its flag, and the flag stays set until it is cleared.
- R7: A too-high event sets bit 0 only while the echo threshold field equals 7. At any other threshold it is ignored.
- R8: Writing 0x7 with bit 0 = 1 clears all three flags.
- R9: Writing 0x7 with bit 1 = 1 clears only the no-signal flag. It also raises the abort output for exactly one cycle, in the cycle after the write.
- R10: The error output is low when any flag is set and high when no flag is set.
- R11: An event that arrives in the same cycle as a clearing write leaves its flag set.
- R12: Reading any register, register 0x7 included, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid one cycle after the strobe |
| ev_weak | input | 1 | Weak-signal event pulse |
| ev_nosig | input | 1 | No-signal event pulse |
| ev_high | input | 1 | Signal-too-high event pulse |
| err_n | output | 1 | Active-low error output |
| meas_abort | output | 1 | One-cycle abort pulse to the measurement sequencer |
| tx_div_sel | output | 3 | Burst clock divider code |
| tx_pulses | output | 5 | Burst pulse count |
| avg_sel | output | 3 | Averaging count code |
| rx_events | output | 3 | Expected receive events |
| tof_mode | output | 2 | Measurement mode |
| echo_thld | output | 3 | Echo qualification threshold code |
| timing_len | output | 10 | Timing length field |
| listen_sel | output | 2 | Listening-window timeout code |

## Verification
The assertions take for granted that bus_wr and bus_rd are never high together on the same address, and that the event inputs are clean synchronous pulses with no X value after reset. The bench drives every strobe and every event on the falling edge and holds each for one cycle. It never issues a read and a write in the same cycle. It pulses events on their own, except in the cases built to test that an event arriving alongside a clearing write still wins.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

   localparam int ERR_IDX    = 7;
   localparam int THLD_IDX   = 3;
   localparam int TLEN_HI    = 5;
   localparam int TLEN_LO    = 6;
   localparam int FLAG_W     = 3;
   localparam int FLAG_HIGH  = 0;
   localparam int FLAG_NONE  = 1;
   localparam int FLAG_WEAK  = 2;

   function automatic logic [7:0] reset_val(input int idx);
      case (idx)
         0:       return 8'h45;
         1:       return 8'h40;
         3:       return 8'h03;
         4:       return 8'h1F;
         8:       return 8'h19;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
   parameter int ADDR_W   = 4,
   parameter int NUM_REGS = 10
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);
   generate
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad
         $error("cfg_addr_dec: NUM_REGS does not fit the address width");
      end
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
         assign sel[i] = (addr == ADDR_W'(i));
      end
   endgenerate

   assign hit = |sel;

   always_comb begin
      assert (!hit || $onehot(sel)) else $error("assert_onehot_sel_R3");
   end
endmodule

// File: rtl/cfg_store_reg.sv
module cfg_store_reg #(
   parameter int         W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/cfg_err_flags.sv
module cfg_err_flags
   import cfg_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              clr_none,
   input  logic              ev_weak,
   input  logic              ev_nosig,
   input  logic              ev_high,
   input  logic              thld_max,
   output logic [FLAG_W-1:0] flags,
   output logic              abort
);
   logic [FLAG_W-1:0] set_v, clr_v;

   always_comb begin
      set_v            = '0;
      set_v[FLAG_WEAK] = ev_weak;
      set_v[FLAG_NONE] = ev_nosig;
      set_v[FLAG_HIGH] = ev_high & thld_max;
      clr_v            = '0;
      if (clr_all)  clr_v = '1;
      if (clr_none) clr_v[FLAG_NONE] = 1'b1;
   end

   // events win over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         abort <= 1'b0;
      end else begin
         flags <= (flags & ~clr_v) | set_v;
         abort <= clr_none;
      end
   end

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FLAG_WEAK] && !clr_all) |=> flags[FLAG_WEAK]);
   assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[FLAG_HIGH] && !(ev_high && thld_max)) |=> !flags[FLAG_HIGH]);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !ev_weak && !ev_nosig && !ev_high) |=> (flags == '0));
   assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_nosig |=> flags[FLAG_NONE]);
   assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !clr_none) |=> !abort);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfg_regbank_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_weak,
   input  logic              ev_nosig,
   input  logic              ev_high,
   output logic              err_n,
   output logic              meas_abort,
   output logic [2:0]        tx_div_sel,
   output logic [4:0]        tx_pulses,
   output logic [2:0]        avg_sel,
   output logic [2:0]        rx_events,
   output logic [1:0]        tof_mode,
   output logic [2:0]        echo_thld,
   output logic [9:0]        timing_len,
   output logic [1:0]        listen_sel
);
   localparam int TLEN_W = 10;
   localparam int HI_W   = TLEN_W - DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("cfg_regbank: field layout needs DATA_W == 8");
      end
      if (NUM_REGS <= ERR_IDX) begin : g_bad_n
         $error("cfg_regbank: bank too small for the error register");
      end
   endgenerate

   logic [NUM_REGS-1:0] sel;
   logic                hit;
   logic [NUM_REGS-1:0] we;
   logic [DATA_W-1:0]   regq [NUM_REGS];
   logic [FLAG_W-1:0]   flags;
   logic [DATA_W-1:0]   rd_mux;
   logic                thld_max;

   cfg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
      .addr(bus_addr), .sel(sel), .hit(hit)
   );

   assign we = sel & {NUM_REGS{bus_wr}};

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         if (i == ERR_IDX) begin : g_err
            assign regq[i] = {{(DATA_W-FLAG_W){1'b0}}, flags};
         end else begin : g_rw
            cfg_store_reg #(.W(DATA_W), .RST(DATA_W'(reset_val(i)))) u_r (
               .clk(clk), .rst_n(rst_n), .we(we[i]),
               .d(bus_wdata), .q(regq[i])
            );
         end
      end
   endgenerate

   assign thld_max = (regq[THLD_IDX][2:0] == 3'h7);

   cfg_err_flags u_err (
      .clk(clk), .rst_n(rst_n),
      .clr_all (we[ERR_IDX] & bus_wdata[FLAG_HIGH]),
      .clr_none(we[ERR_IDX] & bus_wdata[FLAG_NONE]),
      .ev_weak(ev_weak), .ev_nosig(ev_nosig), .ev_high(ev_high),
      .thld_max(thld_max), .flags(flags), .abort(meas_abort)
   );

   assign err_n = ~|flags;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (sel[i]) rd_mux = regq[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign tx_div_sel = regq[0][7:5];
   assign tx_pulses  = regq[0][4:0];
   assign avg_sel    = regq[1][5:3];
   assign rx_events  = regq[1][2:0];
   assign tof_mode   = regq[2][1:0];
   assign echo_thld  = regq[THLD_IDX][2:0];
   assign timing_len = {regq[TLEN_HI][HI_W-1:0], regq[TLEN_LO]};
   assign listen_sel = regq[8][1:0];

   assert_rd_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> (bus_rdata == '0));
   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ERR_IDX) && bus_wdata[FLAG_NONE]) |=> meas_abort);
   assert_err_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_weak |=> !err_n);
endmodule

// File: tb/sim_cfg_regbank.sv
module sim_cfg_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       ev_weak = 1'b0, ev_nosig = 1'b0, ev_high = 1'b0;
   logic       err_n, meas_abort;
   logic [2:0] tx_div_sel, avg_sel, rx_events, echo_thld;
   logic [4:0] tx_pulses;
   logic [1:0] tof_mode, listen_sel;
   logic [9:0] timing_len;

   always #2.5 clk = ~clk;

   cfg_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ev_weak(ev_weak), .ev_nosig(ev_nosig), .ev_high(ev_high),
      .err_n(err_n), .meas_abort(meas_abort),
      .tx_div_sel(tx_div_sel), .tx_pulses(tx_pulses), .avg_sel(avg_sel),
      .rx_events(rx_events), .tof_mode(tof_mode), .echo_thld(echo_thld),
      .timing_len(timing_len), .listen_sel(listen_sel)
   );

   int         n_cmp = 0, n_bad = 0;
   bit         done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mdl [10];
   logic       rd_q = 1'b0;

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: compare read data one cycle after each strobe
   always @(posedge clk) rd_q <= bus_rd;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: unexpected read data %0h expected none", bus_rdata);
         end else begin
            chk({8'h0, bus_rdata}, {8'h0, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   task automatic do_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_wr_ev(input logic [3:0] a, input logic [7:0] d,
                           input logic w, input logic n, input logic h);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      ev_weak = w; ev_nosig = n; ev_high = h;
      @(negedge clk);
      bus_wr = 1'b0; ev_weak = 0; ev_nosig = 0; ev_high = 0;
      if (a < 4'd10 && a != 4'd7) mdl[a] = d;
   endtask

   task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
      do_wr_ev(a, d, 0, 0, 0);
   endtask

   task automatic do_ev(input logic w, input logic n, input logic h);
      @(negedge clk);
      ev_weak = w; ev_nosig = n; ev_high = h;
      @(negedge clk);
      ev_weak = 0; ev_nosig = 0; ev_high = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      mdl[0] = 8'h45; mdl[1] = 8'h40; mdl[2] = 8'h00; mdl[3] = 8'h03; mdl[4] = 8'h1F;
      mdl[5] = 8'h00; mdl[6] = 8'h00; mdl[7] = 8'h00; mdl[8] = 8'h19; mdl[9] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk({15'h0, err_n}, 16'h1, "R10 reset err_n");
      chk({15'h0, meas_abort}, 16'h0, "R9 reset abort");
      chk({6'h0, timing_len}, 16'h0, "R4 reset timing");
      chk({13'h0, echo_thld}, 16'h3, "R4 reset threshold");
      for (int i = 0; i < 10; i++) do_rd(4'(i), mdl[i], "R1 reset value");
      for (int i = 10; i < 16; i++) do_rd(4'(i), 8'h00, "R3 reserved read");

      // R2 write/read of every plain register
      for (int i = 0; i < 10; i++)
         if (i != 7) do_wr(4'(i), 8'((i * 29 + 90) & 255));
      for (int i = 0; i < 10; i++)
         if (i != 7) do_rd(4'(i), mdl[i], "R2 readback");

      // R4 timing split
      do_wr(4'd5, 8'hFE);
      do_wr(4'd6, 8'h34);
      chk({6'h0, timing_len}, 16'h234, "R4 timing field");
      do_rd(4'd5, 8'hFE, "R2 all bits stored");

      // R3 reserved writes
      for (int i = 10; i < 16; i++) do_wr(4'(i), 8'hFF);
      for (int i = 0; i < 10; i++) do_rd(4'(i), mdl[i], "R3 unchanged after reserved write");

      // R5 writes never set flags
      do_wr(4'd7, 8'hFF);
      do_rd(4'd7, 8'h00, "R5 write does not set");

      // R7 gating
      do_wr(4'd3, 8'h00);
      chk({13'h0, echo_thld}, 16'h0, "R4 threshold field");
      do_ev(0, 0, 1);
      chk({15'h0, err_n}, 16'h1, "R7 high ignored err_n");
      do_rd(4'd7, 8'h00, "R7 high ignored");
      do_wr(4'd3, 8'h07);
      do_ev(0, 0, 1);
      chk({15'h0, err_n}, 16'h0, "R10 err_n low");
      do_rd(4'd7, 8'h01, "R7 high accepted");

      // R6 sticky events, R12 read without side effect
      do_ev(1, 0, 0);
      do_ev(0, 1, 0);
      do_rd(4'd7, 8'h07, "R6 flags set");
      do_rd(4'd7, 8'h07, "R12 read no side effect");

      // R9 clear no-signal with abort pulse
      do_wr(4'd7, 8'h02);
      chk({15'h0, meas_abort}, 16'h1, "R9 abort pulse");
      @(negedge clk);
      chk({15'h0, meas_abort}, 16'h0, "R9 abort single cycle");
      do_rd(4'd7, 8'h05, "R9 only no-signal cleared");

      // R5 weak bit not writable
      do_wr(4'd7, 8'h04);
      do_rd(4'd7, 8'h05, "R5 weak bit read-only");

      // R8 clear all
      do_wr(4'd7, 8'h01);
      chk({15'h0, err_n}, 16'h1, "R8 err_n released");
      chk({15'h0, meas_abort}, 16'h0, "R8 no abort");
      do_rd(4'd7, 8'h00, "R8 all cleared");

      // R11 event beats clear
      do_wr_ev(4'd7, 8'h01, 0, 1, 0);
      do_rd(4'd7, 8'h02, "R11 event beats clear-all");
      do_wr_ev(4'd7, 8'h02, 0, 1, 0);
      chk({15'h0, meas_abort}, 16'h1, "R9 abort with concurrent event");
      do_rd(4'd7, 8'h02, "R11 event beats clear-one");
      chk({15'h0, err_n}, 16'h0, "R10 err_n still low");
      do_wr(4'd7, 8'h01);
      do_rd(4'd7, 8'h00, "R8 final clear");

      repeat (3) @(negedge clk);
      chk(16'(exp_q.size()), 16'h0, "R2 all reads returned");
      finish_run();
   end
endmodule